// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block brings one gated logic domain down or up by walking a fixed order of control actions. It drives the domain's reset, isolation clamp, clock gate, two power-switch stages, the SRAM sleep request, the retention clock gate and the retention save and load strobes. It also drives a bus-protection enable word, one parameterised step at a time. Every switch stage, the SRAM and the protection steps that need it are gated on an acknowledge. Each acknowledge wait has a timeout counted in microsecond strokes from an internal divider.

A command carries one bit that selects power-up or power-down. The block raises `busy` for the whole sequence and ends it with a one-cycle `done`. An `err` flag and an error code are valid in that same cycle. Commands are only accepted after a one-time unlock word has been written. The state of the retention flops is tracked inside the block, so a restore is performed only when a save preceded it.

Top module: `pd_switch_seq`

## Requirements
- R1: A command is ignored, with no output change and no `done`, until `cfg_wr` has been pulsed with `cfg_wdata` equal to 0x0B16_0001 (key 0xB16 in bits 31:16, bit 0 set). Any other word leaves the block locked.
- R2: Power-down runs in this order: protection steps, SRAM sleep, retention save, then `dom_iso` set, `dom_clk_off` set, `dom_rst_n` cleared, `sw1_en` cleared and wait for `sw1_ack` low, `sw2_en` cleared and wait for `sw2_ack` low.
- R3: Power-up runs in this order: `sw1_en` set and wait for `sw1_ack` high, wait ON_SETTLE_US, `sw2_en` set and wait for `sw2_ack` high, `dom_clk_off` cleared, `dom_iso` cleared, wait ISO_SETTLE_US, `dom_rst_n` set.
- R4: The retention save is a high pulse on `ret_save` and the load is a low pulse on `ret_load_n`. Each pulse lies inside a window where `ret_clk_off` is high. The load runs on power-up after reset release only if a save completed since the previous load. After reset no save is recorded.
- R5: With HAS_SRAM set, power-down raises `sram_sleep` and waits for `sram_sleep_ack` high before the save. Power-up clears it and waits for the acknowledge low after the load, before the protection release.
- R6: On power-down, step i ORs its mask (bits [i*PROT_W +: PROT_W] of PROT_MASKS) into `prot_en`. On power-up, step i clears the mask from `prot_en`. Steps run in index order. A step whose PROT_HAS_RDY bit is set waits until every mask bit of `prot_rdy` is high (down) or low (up).
- R7: An acknowledge wait not met within POLL_LIMIT microsecond strokes aborts the sequence at once. No further output changes. `done` is raised with `err` high and `err_code` = 25.
- R8: A protection-release wait that times out during power-up ends the sequence with `err` low. The release steps after it are skipped.
- R9: `busy` is high from the cycle after an accepted command until `done`. `done` is high for exactly one cycle per sequence. A command presented while `busy` is high is ignored.
- R10: The microsecond stroke fires once every CLK_PER_US cycles. Delays and timeouts are counted in these strokes.
- R11: After reset: `dom_rst_n`=0, `dom_iso`=1, `sw1_en`=`sw2_en`=0, `dom_clk_off`=1, `sram_sleep`=HAS_SRAM, `ret_clk_off`=0, `ret_save`=0, `ret_load_n`=1, `prot_en`= the OR of all masks, and `busy`=`done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Unlock word write strobe |
| cfg_wdata | input | 32 | Unlock word |
| cmd_valid | input | 1 | Command strobe |
| cmd_up | input | 1 | 1 = power up, 0 = power down |
| sw1_ack | input | 1 | Primary switch acknowledge |
| sw2_ack | input | 1 | Secondary switch acknowledge |
| sram_sleep_ack | input | 1 | SRAM sleep acknowledge |
| prot_rdy | input | PROT_W | Bus-protection ready bits |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | Sequence aborted on timeout (valid with done) |
| err_code | output | 8 | 25 on timeout, else 0 (valid with done) |
| dom_rst_n | output | 1 | Domain reset, active low |
| dom_iso | output | 1 | Domain output isolation |
| sw1_en | output | 1 | Primary switch enable |
| sw2_en | output | 1 | Secondary switch enable |
| dom_clk_off | output | 1 | Domain clock disable |
| sram_sleep | output | 1 | SRAM power-down request |
| ret_clk_off | output | 1 | Retention clock gate |
| ret_save | output | 1 | Retention save strobe |
| ret_load_n | output | 1 | Retention load strobe, active low |
| prot_en | output | PROT_W | Bus-protection enable word |

## Verification
The bench builds the block with CLK_PER_US=2, POLL_LIMIT=8, ON_SETTLE_US=5 and ISO_SETTLE_US=3. This keeps every delay and timeout within a few dozen cycles, so aborts and settle windows can be checked exactly against cycle stamps. It keeps HAS_SRAM set. It uses two protection steps: one with a ready handshake and one without. This covers the wait and no-wait paths, and a stuck ready bit can cut the release after step 0. A responder with random acknowledge latency below the timeout drives alternating commands.

// File: rtl/pds_pkg.sv
package pds_pkg;

  localparam logic [15:0] UNLOCK_KEY  = 16'hB16;
  localparam logic [31:0] UNLOCK_WORD = {UNLOCK_KEY, 15'd0, 1'b1};
  localparam logic [7:0]  ERR_TIMEOUT = 8'd25;

  typedef enum logic [4:0] {
    S_IDLE,
    S_PROT_DRIVE,
    S_PROT_WAIT,
    S_SRAM_DRIVE,
    S_SRAM_WAIT,
    S_RET_GATE,
    S_RET_PULSE,
    S_RET_END,
    S_RET_UNGATE,
    S_ISO_ON,
    S_CLK_OFF,
    S_RST_ON,
    S_SW1_DRIVE,
    S_SW1_WAIT,
    S_SETTLE,
    S_SW2_DRIVE,
    S_SW2_WAIT,
    S_CLK_ON,
    S_ISO_OFF,
    S_ISO_DLY,
    S_RST_OFF,
    S_FINISH
  } seq_state_e;

endpackage

// File: rtl/pds_usec_tick.sv
module pds_usec_tick #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV == 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else if (cnt_q == CW'(DIV - 1)) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
      end
      assign tick = (cnt_q == CW'(DIV - 1));

      AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R10
    end
  endgenerate
endmodule

// File: rtl/pds_wait_timer.sv
module pds_wait_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (tick && !hit) cnt_q <= cnt_q + 1'b1;
  end

  assign hit = (cnt_q >= limit);
endmodule

// File: rtl/pd_switch_seq.sv
module pd_switch_seq #(
  parameter int CLK_PER_US    = 100,
  parameter int POLL_LIMIT    = 500,
  parameter int ON_SETTLE_US  = 50,
  parameter int ISO_SETTLE_US = 10,
  parameter bit HAS_SRAM      = 1'b1,
  parameter int PROT_W        = 8,
  parameter int PROT_STEPS    = 2,
  parameter logic [PROT_STEPS*PROT_W-1:0] PROT_MASKS = {8'h30, 8'h03},
  parameter logic [PROT_STEPS-1:0]        PROT_HAS_RDY = 2'b01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_wdata,
  input  logic              cmd_valid,
  input  logic              cmd_up,
  input  logic              sw1_ack,
  input  logic              sw2_ack,
  input  logic              sram_sleep_ack,
  input  logic [PROT_W-1:0] prot_rdy,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [7:0]        err_code,
  output logic              dom_rst_n,
  output logic              dom_iso,
  output logic              sw1_en,
  output logic              sw2_en,
  output logic              dom_clk_off,
  output logic              sram_sleep,
  output logic              ret_clk_off,
  output logic              ret_save,
  output logic              ret_load_n,
  output logic [PROT_W-1:0] prot_en
);
  import pds_pkg::*;

  localparam int MAX_A   = (POLL_LIMIT > ON_SETTLE_US) ? POLL_LIMIT : ON_SETTLE_US;
  localparam int CNT_MAX = (MAX_A > ISO_SETTLE_US) ? MAX_A : ISO_SETTLE_US;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int IDX_W   = (PROT_STEPS > 1) ? $clog2(PROT_STEPS) : 1;

  function automatic logic [PROT_W-1:0] or_masks();
    logic [PROT_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < PROT_STEPS; i++) acc = acc | PROT_MASKS[i*PROT_W +: PROT_W];
    return acc;
  endfunction

  localparam logic [PROT_W-1:0] PROT_ALL = or_masks();

  seq_state_e       st_q, st_d;
  logic             dir_up_q;
  logic [IDX_W-1:0] idx_q;
  logic             saved_q;
  logic             err_q;
  logic             unlocked_q;
  logic             enter_q;
  logic             us_tick;
  logic             tmr_hit;
  logic [CNT_W-1:0] tmr_limit;
  logic             timeout;
  logic             start;
  logic [PROT_W-1:0] step_mask;
  logic             step_rdy;
  logic             step_last;
  logic             prot_ok;
  seq_state_e       prot_exit;

  pds_usec_tick #(.DIV(CLK_PER_US)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(us_tick)
  );

  always_comb begin
    case (st_q)
      S_SETTLE:  tmr_limit = CNT_W'(ON_SETTLE_US);
      S_ISO_DLY: tmr_limit = CNT_W'(ISO_SETTLE_US);
      default:   tmr_limit = CNT_W'(POLL_LIMIT);
    endcase
  end

  pds_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .clr  (enter_q),
    .tick (us_tick),
    .limit(tmr_limit),
    .hit  (tmr_hit)
  );

  assign timeout   = tmr_hit && !enter_q;
  assign start     = (st_q == S_IDLE) && cmd_valid && unlocked_q;
  assign step_mask = PROT_MASKS[int'(idx_q)*PROT_W +: PROT_W];
  assign step_rdy  = PROT_HAS_RDY[idx_q];
  assign step_last = (idx_q == IDX_W'(PROT_STEPS - 1));
  assign prot_ok   = dir_up_q ? ((prot_rdy & step_mask) == '0)
                              : ((prot_rdy & step_mask) == step_mask);
  assign prot_exit = dir_up_q ? S_FINISH : S_SRAM_DRIVE;

  // next state
  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE:       if (start) st_d = cmd_up ? S_SW1_DRIVE : S_PROT_DRIVE;
      S_PROT_DRIVE: st_d = step_rdy ? S_PROT_WAIT : (step_last ? prot_exit : S_PROT_DRIVE);
      S_PROT_WAIT: begin
        if (prot_ok) st_d = step_last ? prot_exit : S_PROT_DRIVE;
        else if (timeout) st_d = S_FINISH;
      end
      S_SRAM_DRIVE: st_d = HAS_SRAM ? S_SRAM_WAIT : (dir_up_q ? S_PROT_DRIVE : S_RET_GATE);
      S_SRAM_WAIT: begin
        if (sram_sleep_ack == !dir_up_q) st_d = dir_up_q ? S_PROT_DRIVE : S_RET_GATE;
        else if (timeout) st_d = S_FINISH;
      end
      S_RET_GATE:   st_d = S_RET_PULSE;
      S_RET_PULSE:  st_d = S_RET_END;
      S_RET_END:    st_d = S_RET_UNGATE;
      S_RET_UNGATE: st_d = dir_up_q ? S_SRAM_DRIVE : S_ISO_ON;
      S_ISO_ON:     st_d = S_CLK_OFF;
      S_CLK_OFF:    st_d = S_RST_ON;
      S_RST_ON:     st_d = S_SW1_DRIVE;
      S_SW1_DRIVE:  st_d = S_SW1_WAIT;
      S_SW1_WAIT: begin
        if (sw1_ack == dir_up_q) st_d = dir_up_q ? S_SETTLE : S_SW2_DRIVE;
        else if (timeout) st_d = S_FINISH;
      end
      S_SETTLE:     if (timeout) st_d = S_SW2_DRIVE;
      S_SW2_DRIVE:  st_d = S_SW2_WAIT;
      S_SW2_WAIT: begin
        if (sw2_ack == dir_up_q) st_d = dir_up_q ? S_CLK_ON : S_FINISH;
        else if (timeout) st_d = S_FINISH;
      end
      S_CLK_ON:     st_d = S_ISO_OFF;
      S_ISO_OFF:    st_d = S_ISO_DLY;
      S_ISO_DLY:    if (timeout) st_d = S_RST_OFF;
      S_RST_OFF:    st_d = saved_q ? S_RET_GATE : S_SRAM_DRIVE;
      S_FINISH:     st_d = S_IDLE;
      default:      st_d = S_IDLE;
    endcase
  end

  // state, bookkeeping and registered domain controls
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= S_IDLE;
      enter_q     <= 1'b1;
      dir_up_q    <= 1'b0;
      idx_q       <= '0;
      saved_q     <= 1'b0;
      err_q       <= 1'b0;
      unlocked_q  <= 1'b0;
      dom_rst_n   <= 1'b0;
      dom_iso     <= 1'b1;
      sw1_en      <= 1'b0;
      sw2_en      <= 1'b0;
      dom_clk_off <= 1'b1;
      sram_sleep  <= HAS_SRAM;
      ret_clk_off <= 1'b0;
      ret_save    <= 1'b0;
      ret_load_n  <= 1'b1;
      prot_en     <= PROT_ALL;
    end else begin
      st_q    <= st_d;
      enter_q <= (st_d != st_q);
      if (cfg_wr && cfg_wdata == UNLOCK_WORD) unlocked_q <= 1'b1;
      case (st_q)
        S_IDLE: if (start) begin
          dir_up_q <= cmd_up;
          idx_q    <= '0;
          err_q    <= 1'b0;
        end
        S_PROT_DRIVE: begin
          prot_en <= dir_up_q ? (prot_en & ~step_mask) : (prot_en | step_mask);
          if (!step_rdy && !step_last) idx_q <= idx_q + 1'b1;
        end
        S_PROT_WAIT: begin
          if (prot_ok) begin
            if (!step_last) idx_q <= idx_q + 1'b1;
          end else if (timeout && !dir_up_q) begin
            err_q <= 1'b1;
          end
        end
        S_SRAM_DRIVE: begin
          if (HAS_SRAM) sram_sleep <= !dir_up_q;
          idx_q <= '0;
        end
        S_SRAM_WAIT:  if (sram_sleep_ack != !dir_up_q && timeout) err_q <= 1'b1;
        S_RET_GATE:   ret_clk_off <= 1'b1;
        S_RET_PULSE: begin
          if (dir_up_q) ret_load_n <= 1'b0;
          else ret_save <= 1'b1;
        end
        S_RET_END: begin
          ret_save   <= 1'b0;
          ret_load_n <= 1'b1;
        end
        S_RET_UNGATE: begin
          ret_clk_off <= 1'b0;
          saved_q     <= !dir_up_q;
        end
        S_ISO_ON:     dom_iso <= 1'b1;
        S_CLK_OFF:    dom_clk_off <= 1'b1;
        S_RST_ON:     dom_rst_n <= 1'b0;
        S_SW1_DRIVE:  sw1_en <= dir_up_q;
        S_SW1_WAIT:   if (sw1_ack != dir_up_q && timeout) err_q <= 1'b1;
        S_SW2_DRIVE:  sw2_en <= dir_up_q;
        S_SW2_WAIT:   if (sw2_ack != dir_up_q && timeout) err_q <= 1'b1;
        S_CLK_ON:     dom_clk_off <= 1'b0;
        S_ISO_OFF:    dom_iso <= 1'b0;
        S_RST_OFF:    dom_rst_n <= 1'b1;
        default: ;
      endcase
    end
  end

  assign busy     = (st_q != S_IDLE);
  assign done     = (st_q == S_FINISH);
  assign err      = done && err_q;
  assign err_code = (done && err_q) ? ERR_TIMEOUT : 8'd0;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_SW1_OFF_SAFE: assert property (@(posedge clk) disable iff (rst)
    $fell(sw1_en) |-> (dom_iso && dom_clk_off && !dom_rst_n)); // R2
  AST_RST_RELEASE_SAFE: assert property (@(posedge clk) disable iff (rst)
    $rose(dom_rst_n) |-> (!dom_iso && !dom_clk_off && sw2_en && sw1_en)); // R3
  AST_SW2_AFTER_SW1: assert property (@(posedge clk) disable iff (rst)
    $rose(sw2_en) |-> sw1_en); // R3
  AST_SAVE_GATED: assert property (@(posedge clk) disable iff (rst)
    ret_save |-> ret_clk_off); // R4
  AST_LOAD_GATED: assert property (@(posedge clk) disable iff (rst)
    !ret_load_n |-> ret_clk_off); // R4
  AST_ERR_CODE: assert property (@(posedge clk) disable iff (rst)
    err |-> (done && err_code == 8'd25)); // R7
  AST_LOCKED_IDLE: assert property (@(posedge clk) disable iff (rst)
    !unlocked_q |-> !busy); // R1
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy); // R9
endmodule

// File: tb/pd_switch_seq_bench.sv
module pd_switch_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CPU  = 2;
  localparam int PL   = 8;
  localparam int ONUS = 5;
  localparam int ISUS = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic cmd_valid = 1'b0;
  logic cmd_up = 1'b0;
  logic sw1_ack = 1'b0, sw2_ack = 1'b0, sram_sleep_ack = 1'b1;
  logic [7:0] prot_rdy = 8'h33;
  logic busy, done, err;
  logic [7:0] err_code;
  logic dom_rst_n, dom_iso, sw1_en, sw2_en, dom_clk_off, sram_sleep;
  logic ret_clk_off, ret_save, ret_load_n;
  logic [7:0] prot_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  pd_switch_seq #(
    .CLK_PER_US(CPU), .POLL_LIMIT(PL), .ON_SETTLE_US(ONUS), .ISO_SETTLE_US(ISUS),
    .HAS_SRAM(1'b1), .PROT_W(8), .PROT_STEPS(2),
    .PROT_MASKS({8'h30, 8'h03}), .PROT_HAS_RDY(2'b01)
  ) u_pd_switch_seq (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cmd_valid(cmd_valid), .cmd_up(cmd_up), .sw1_ack(sw1_ack), .sw2_ack(sw2_ack),
    .sram_sleep_ack(sram_sleep_ack), .prot_rdy(prot_rdy), .busy(busy), .done(done),
    .err(err), .err_code(err_code), .dom_rst_n(dom_rst_n), .dom_iso(dom_iso),
    .sw1_en(sw1_en), .sw2_en(sw2_en), .dom_clk_off(dom_clk_off), .sram_sleep(sram_sleep),
    .ret_clk_off(ret_clk_off), .ret_save(ret_save), .ret_load_n(ret_load_n), .prot_en(prot_en)
  );

  int total = 0, bad = 0, cyc = 0;
  int lat = 1;
  bit stuck_sw1 = 1'b0;
  logic [7:0] stuck_prot = 8'h00;
  int c1 = 0, c2 = 0, c3 = 0;
  logic [7:0] prot_d = 8'h33;
  logic [16:0] prev_v = '0;
  int ev_q[$];
  int exp_q[$];
  int done_hi = 0;
  int t_ack1 = 0, t_sw2 = 0, t_isof = 0, t_rstr = 0;

  // domain responder and output monitor, both away from the active edge
  always @(negedge clk) begin
    logic [16:0] cur;
    cyc++;
    if (stuck_sw1) sw1_ack = 1'b1;
    else if (sw1_ack != sw1_en) begin
      if (c1 >= lat) begin sw1_ack = sw1_en; c1 = 0; if (sw1_en) t_ack1 = cyc; end
      else c1++;
    end else c1 = 0;
    if (sw2_ack != sw2_en) begin
      if (c2 >= lat) begin sw2_ack = sw2_en; c2 = 0; end else c2++;
    end else c2 = 0;
    if (sram_sleep_ack != sram_sleep) begin
      if (c3 >= lat) begin sram_sleep_ack = sram_sleep; c3 = 0; end else c3++;
    end else c3 = 0;
    prot_rdy = prot_d | stuck_prot;
    prot_d = prot_en;
    cur = {prot_en, ret_load_n, ret_save, ret_clk_off, sram_sleep, dom_clk_off,
           sw2_en, sw1_en, dom_iso, dom_rst_n};
    if (!rst) begin
      for (int i = 0; i < 9; i++) if (cur[i] != prev_v[i]) ev_q.push_back(i*1000 + int'(cur[i]));
      if (cur[16:9] != prev_v[16:9]) ev_q.push_back(9000 + int'(cur[16:9]));
      if (cur[3] && !prev_v[3]) t_sw2 = cyc;
      if (!cur[1] && prev_v[1]) t_isof = cyc;
      if (cur[0] && !prev_v[0]) t_rstr = cyc;
      if (done) done_hi++;
    end
    prev_v = cur;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic exp_down();
    exp_q = {9003, 9051, 5001, 6001, 7001, 7000, 6000, 1001, 4001, 0, 2000, 3000};
  endtask

  task automatic exp_up(input bit restore);
    exp_q = {2001, 3001, 4000, 1000, 1};
    if (restore) begin
      exp_q.push_back(6001); exp_q.push_back(8000);
      exp_q.push_back(8001); exp_q.push_back(6000);
    end
    exp_q.push_back(5000); exp_q.push_back(9048); exp_q.push_back(9000);
  endtask

  task automatic cmp_seq(input string req);
    int at = -1;
    int n = (ev_q.size() > exp_q.size()) ? ev_q.size() : exp_q.size();
    for (int i = 0; i < n; i++) begin
      if (at < 0 && (i >= ev_q.size() || i >= exp_q.size() || ev_q[i] != exp_q[i])) at = i;
    end
    chk(at < 0, req, $sformatf("event order at index %0d", at),
        (at >= 0 && at < ev_q.size()) ? ev_q[at] : -1,
        (at >= 0 && at < exp_q.size()) ? exp_q[at] : -1);
  endtask

  task automatic run_cmd(input bit up, input bit poke, output bit e, output int code);
    int n = 0;
    ev_q.delete();
    done_hi = 0;
    @(negedge clk); cmd_valid = 1'b1; cmd_up = up;
    @(negedge clk); cmd_valid = 1'b0;
    if (poke) begin
      repeat (4) @(negedge clk);
      cmd_valid = 1'b1; cmd_up = !up;
      @(negedge clk); cmd_valid = 1'b0;
    end
    while (!done && n < 3000) begin @(negedge clk); n++; end
    e = err;
    code = int'(err_code);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 100000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit e;
    int code;
    bit dom_up;
    bit saved;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk({prot_en, ret_load_n, ret_save, ret_clk_off, sram_sleep, dom_clk_off, sw2_en, sw1_en,
         dom_iso, dom_rst_n} == {8'h33, 9'b100110010}, "R11", "reset outputs",
        int'({prot_en, ret_load_n, ret_save, ret_clk_off, sram_sleep, dom_clk_off, sw2_en,
              sw1_en, dom_iso, dom_rst_n}), int'({8'h33, 9'b100110010}));
    chk(!busy && !done, "R11", "busy/done at reset", int'({busy, done}), 0);

    // R1 locked: commands ignored
    ev_q.delete(); done_hi = 0;
    cmd_valid = 1'b1; cmd_up = 1'b1; @(negedge clk); cmd_valid = 1'b0;
    repeat (20) @(negedge clk);
    chk(ev_q.size() == 0 && done_hi == 0, "R1", "locked command effect", ev_q.size() + done_hi, 0);
    cfg_wr = 1'b1; cfg_wdata = 32'h0B17_0001; @(negedge clk); cfg_wr = 1'b0;
    cmd_valid = 1'b1; @(negedge clk); cmd_valid = 1'b0;
    repeat (20) @(negedge clk);
    chk(ev_q.size() == 0 && done_hi == 0, "R1", "wrong key command effect", ev_q.size() + done_hi, 0);
    cfg_wr = 1'b1; cfg_wdata = 32'h0B16_0001; @(negedge clk); cfg_wr = 1'b0;

    // first power-up: no restore
    run_cmd(1'b1, 1'b0, e, code);
    chk(!e && code == 0, "R9", "up error flag", code, 0);
    exp_up(1'b0); cmp_seq("R3 R4 R5 R6 first up");
    chk(done_hi == 1, "R9", "done width", done_hi, 1);
    chk(t_sw2 - t_ack1 >= (ONUS-1)*CPU && t_sw2 - t_ack1 <= (ONUS+1)*CPU + 4,
        "R3 R10", "settle cycles", t_sw2 - t_ack1, ONUS*CPU);
    chk(t_rstr - t_isof >= (ISUS-1)*CPU && t_rstr - t_isof <= (ISUS+1)*CPU + 4,
        "R3 R10", "iso-to-reset cycles", t_rstr - t_isof, ISUS*CPU);

    // power-down with a command poked while busy
    run_cmd(1'b0, 1'b1, e, code);
    chk(!e, "R9", "down error flag", code, 0);
    exp_down(); cmp_seq("R2 R5 R6 down");
    repeat (20) @(negedge clk);
    chk(!busy && ev_q.size() == exp_q.size(), "R9", "command while busy ignored", ev_q.size(), exp_q.size());

    // power-up after save: restore
    run_cmd(1'b1, 1'b0, e, code);
    exp_up(1'b1); cmp_seq("R4 restore up");

    // R7 timeout on primary switch
    stuck_sw1 = 1'b1;
    run_cmd(1'b0, 1'b0, e, code);
    chk(e && code == 25, "R7", "timeout code", code, 25);
    chk(sw2_en == 1'b1 && sw1_en == 1'b0, "R7", "abort stops before secondary", int'({sw2_en, sw1_en}), 2);
    stuck_sw1 = 1'b0;
    repeat (10) @(negedge clk);
    run_cmd(1'b0, 1'b0, e, code);
    chk(!e && sw2_en == 1'b0, "R7", "retry completes", int'({e, sw2_en}), 0);

    // R8 release timeout on power-up: no error, step 1 skipped
    stuck_prot = 8'h01;
    run_cmd(1'b1, 1'b0, e, code);
    chk(!e && code == 0, "R8", "release timeout error flag", code, 0);
    chk(prot_en == 8'h30, "R8", "later release step skipped", int'(prot_en), 8'h30);
    stuck_prot = 8'h00;
    run_cmd(1'b0, 1'b0, e, code);
    chk(!e, "R8", "down after release timeout", code, 0);

    // random alternating commands with random acknowledge latency
    dom_up = 1'b0; saved = 1'b1;
    for (int k = 0; k < 10; k++) begin
      bit poke;
      lat = $urandom_range(0, 4);
      poke = 1'(($urandom_range(0, 1)));
      run_cmd(!dom_up, poke, e, code);
      chk(!e, "R9", $sformatf("random cmd %0d error", k), code, 0);
      if (dom_up) begin exp_down(); saved = 1'b1; end
      else begin exp_up(saved); saved = 1'b0; end
      cmp_seq(dom_up ? "R2 random down" : "R3 random up");
      chk(done_hi == 1, "R9", "random done width", done_hi, 1);
      dom_up = !dom_up;
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule